// File: doc/BRIEF.md
# UART Interrupt Source and Mask Controller

This block merges the interrupt causes of one UART channel into a single level-sensitive interrupt line. It keeps a 4-bit source register and a 4-bit mask register. Each source bit is raised by a one-cycle set pulse from the channel's datapath. Software clears source bits by writing ones to them, either through the pending port or through the source port. The pending value is the source register with the masked bits removed. The interrupt output is a registered OR of the pending bits.

The transmit cause also re-arms itself. While the FIFOs are enabled and the transmit FIFO holds no more entries than a programmable threshold, the transmit source bit is forced on. The threshold is a 3-bit code multiplied by a factor that depends on the `CHANNEL` parameter, because the channels have FIFOs of different depth. FIFO storage and bit timing belong to neighbouring blocks.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Source bit positions are fixed: bit0 receive, bit1 error, bit2 transmit, bit3 modem. A pulse on `src_set[k]` makes `src_q[k]` read 1 after the next clock edge.
- R2: `pend_q` equals `src_q & ~mask_q` in every cycle.
- R3: `irq` is registered. After each edge it equals the OR of the bits `pend_q` held before that edge, so it lags any register change by one clock.
- R4: When `mask_wr` is high, `mask_q` loads `wr_data` at the next edge. The effect on `irq` follows one clock later.
- R5: When `pend_wr` is high, every source bit written as 1 in `wr_data` is cleared at the next edge. Pending bits clear with them.
- R6: When `src_wr` is high, every source bit written as 1 in `wr_data` is cleared at the next edge.
- R7: If a set and a clear hit the same bit in the same cycle, the set wins and the bit reads 1. This applies to both an external pulse and the transmit re-arm.
- R8: When `fifo_en` is 1 and `tx_count` <= `tx_code` × M, source bit2 is set at the next edge. M is 32 for CHANNEL 0, 8 for CHANNEL 1, and 2 for channels 2 and 3. With code 0 the threshold is 0, so an empty FIFO still sets the bit.
- R9: When `fifo_en` is 0, the transmit re-arm has no effect whatever the count and code are.
- R10: While `rst_n` is low at a clock edge, the source register, mask register and `irq` all clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_set | input | 4 | One-cycle set pulses per source (bit0 rx, bit1 err, bit2 tx, bit3 modem) |
| fifo_en | input | 1 | FIFO mode enable; gates the transmit re-arm |
| tx_code | input | 3 | Transmit threshold code |
| tx_count | input | 8 | Current transmit FIFO occupancy |
| pend_wr | input | 1 | Write strobe: clear sources through the pending port |
| src_wr | input | 1 | Write strobe: clear sources through the source port |
| mask_wr | input | 1 | Write strobe: load mask |
| wr_data | input | 4 | Write data for all three strobes |
| src_q | output | 4 | Source register |
| mask_q | output | 4 | Mask register |
| pend_q | output | 4 | Pending value, source and not mask |
| irq | output | 1 | Registered interrupt line |

## Verification
Single-bit and multi-bit set patterns, each with masks that hide none, some or all of the set bits, separate the masking from the OR that drives `irq`. Every row also checks the one-clock lag of `irq`. A set and a clear on the same bit in one cycle shows which of the two wins. Transmit counts exactly at the threshold and one above it, with code 0, code 7 and FIFOs disabled, pin down the `<=` comparison and the enable gating. A second instance with CHANNEL 2 receives the same stimulus as the CHANNEL 0 instance. A count that sits between the two thresholds shows that each instance uses its own multiplier.

// File: rtl/uart_irq_pkg.sv
// Shared constants for the UART interrupt controller.
// Assumes four interrupt causes in a fixed bit order.
package uart_irq_pkg;
    localparam int NSRC    = 4;
    localparam int SRC_RX  = 0;
    localparam int SRC_ERR = 1;
    localparam int SRC_TX  = 2;
    localparam int SRC_MDM = 3;

    // Threshold multiplier per channel, sized to each channel's FIFO depth
    function automatic int tx_level_mult(input int ch);
        case (ch)
            0:       return 32;
            1:       return 8;
            default: return 2;
        endcase
    endfunction
endpackage

// File: rtl/irq_tx_level.sv
// Transmit re-arm request: high while FIFOs are on and the transmit
// occupancy is at or below code * multiplier(CHANNEL).
// Assumes code and count are stable inputs sampled by the caller.
module irq_tx_level #(
    parameter int CHANNEL = 0,
    parameter int CODE_W  = 3,
    parameter int CNT_W   = 8
) (
    input  logic              fifo_en,
    input  logic [CODE_W-1:0] code,
    input  logic [CNT_W-1:0]  count,
    output logic              tx_req
);
    localparam int MULT  = uart_irq_pkg::tx_level_mult(CHANNEL);
    localparam int LVL_W = CODE_W + $clog2(MULT) + 1;
    localparam int CMP_W = ((LVL_W > CNT_W) ? LVL_W : CNT_W) + 1;

    logic [CMP_W-1:0] level;

    // Threshold scaling and comparison
    always_comb begin
        level  = CMP_W'(code) * CMP_W'(MULT);
        tx_req = fifo_en && (CMP_W'(count) <= level);
    end
endmodule

// File: rtl/irq_src_reg.sv
// Source register: bits are set by pulses and cleared by write-one-to-clear.
// A set always wins over a clear on the same bit in the same cycle.
module irq_src_reg #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_vec,
    input  logic [NSRC-1:0] clr_vec,
    output logic [NSRC-1:0] src_q
);
    // Clear first, then apply sets so that sets take priority
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= (src_q & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/irq_out_stage.sv
// Pending mask-out and registered interrupt line.
// Assumes source and mask come straight from registers.
module irq_out_stage #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_q,
    input  logic [NSRC-1:0] mask_q,
    output logic [NSRC-1:0] pend_q,
    output logic            irq
);
    // Pending is sources with masked bits removed
    always_comb pend_q = src_q & ~mask_q;

    // Interrupt line registered to break the path to the interrupt fabric
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |pend_q;
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
// UART interrupt controller top: source/mask registers, transmit re-arm,
// pending value and a registered level interrupt.
// Assumes one write strobe set shares wr_data; strobes may coincide.
module uart_irq_ctrl #(
    parameter int CHANNEL = 0,
    parameter int CODE_W  = 3,
    parameter int CNT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        src_set,
    input  logic              fifo_en,
    input  logic [CODE_W-1:0] tx_code,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic              pend_wr,
    input  logic              src_wr,
    input  logic              mask_wr,
    input  logic [3:0]        wr_data,
    output logic [3:0]        src_q,
    output logic [3:0]        mask_q,
    output logic [3:0]        pend_q,
    output logic              irq
);
    import uart_irq_pkg::*;

    logic            tx_req;
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] clr_vec;

    irq_tx_level #(.CHANNEL(CHANNEL), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_lvl (
        .fifo_en (fifo_en),
        .code    (tx_code),
        .count   (tx_count),
        .tx_req  (tx_req)
    );

    // Merge external pulses with the transmit re-arm on its own bit
    for (genvar i = 0; i < NSRC; i++) begin : g_set
        if (i == SRC_TX) begin : g_tx
            assign set_vec[i] = src_set[i] | tx_req;
        end else begin : g_plain
            assign set_vec[i] = src_set[i];
        end
    end

    // Either clear port removes the written bits from the sources
    always_comb clr_vec = (pend_wr || src_wr) ? wr_data : '0;

    irq_src_reg #(.NSRC(NSRC)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .src_q   (src_q)
    );

    // Mask register loaded by software
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= wr_data;
    end

    irq_out_stage #(.NSRC(NSRC)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_q  (src_q),
        .mask_q (mask_q),
        .pend_q (pend_q),
        .irq    (irq)
    );
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
// Property checker for uart_irq_ctrl, attached by bind.
module uart_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] src_set,
    input logic       fifo_en,
    input logic [7:0] tx_count,
    input logic       pend_wr,
    input logic       src_wr,
    input logic       mask_wr,
    input logic [3:0] wr_data,
    input logic [3:0] src_q,
    input logic [3:0] mask_q,
    input logic [3:0] pend_q,
    input logic       irq
);
    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set != 4'd0) |=> ((src_q & $past(src_set)) == $past(src_set)));   // R1
    AST_PEND_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & mask_q) == 4'd0);                                            // R2
    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(src_q & ~mask_q))));                          // R3
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask_q == $past(wr_data)));                               // R4
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_wr || src_wr) && src_set == 4'd0 && !fifo_en)
        |=> ((src_q & $past(wr_data)) == 4'd0));                               // R5
    AST_TX_EMPTY_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && tx_count == 8'd0) |=> src_q[2]);                           // R8
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && src_set == 4'd0) |=> ((src_q & ~$past(src_q)) == 4'd0));  // R9
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk chk (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .fifo_en(fifo_en),
    .tx_count(tx_count), .pend_wr(pend_wr), .src_wr(src_wr),
    .mask_wr(mask_wr), .wr_data(wr_data), .src_q(src_q), .mask_q(mask_q),
    .pend_q(pend_q), .irq(irq)
);

// File: tb/uart_irq_ctrl_test.sv
`timescale 1ns/1ps
module uart_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_set = '0;
    logic       fifo_en = 1'b0;
    logic [2:0] tx_code = '0;
    logic [7:0] tx_count = '0;
    logic       pend_wr = 1'b0, src_wr = 1'b0, mask_wr = 1'b0;
    logic [3:0] wr_data = '0;
    logic [3:0] src_q, mask_q, pend_q, src_q2, mask_q2, pend_q2;
    logic       irq, irq2;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [3:0] prev_pend = '0;

    always #2.5 clk = ~clk;

    uart_irq_ctrl #(.CHANNEL(0)) uut (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .fifo_en(fifo_en),
        .tx_code(tx_code), .tx_count(tx_count), .pend_wr(pend_wr),
        .src_wr(src_wr), .mask_wr(mask_wr), .wr_data(wr_data),
        .src_q(src_q), .mask_q(mask_q), .pend_q(pend_q), .irq(irq));

    uart_irq_ctrl #(.CHANNEL(2)) uut_c2 (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .fifo_en(fifo_en),
        .tx_code(tx_code), .tx_count(tx_count), .pend_wr(pend_wr),
        .src_wr(src_wr), .mask_wr(mask_wr), .wr_data(wr_data),
        .src_q(src_q2), .mask_q(mask_q2), .pend_q(pend_q2), .irq(irq2));

    // Row: set4 fen1 code3 cnt8 op2 (0 none,1 pend,2 src,3 mask) wdata4 exp_src4 exp_mask4
    localparam int NV = 16;
    localparam logic [29:0] VEC [NV] = '{
        {4'b0001, 1'b0, 3'd0, 8'd0,   2'd0, 4'b0000, 4'b0001, 4'b0000}, // R1 rx
        {4'b1000, 1'b0, 3'd0, 8'd0,   2'd0, 4'b0000, 4'b1001, 4'b0000}, // R1 modem
        {4'b0000, 1'b0, 3'd0, 8'd0,   2'd3, 4'b0001, 4'b1001, 4'b0001}, // R4 partial mask
        {4'b0000, 1'b0, 3'd0, 8'd0,   2'd3, 4'b1001, 4'b1001, 4'b1001}, // R4 full mask
        {4'b0000, 1'b0, 3'd0, 8'd0,   2'd1, 4'b1000, 4'b0001, 4'b1001}, // R5
        {4'b0000, 1'b0, 3'd0, 8'd0,   2'd3, 4'b0000, 4'b0001, 4'b0000}, // R4 unmask
        {4'b0000, 1'b0, 3'd0, 8'd0,   2'd2, 4'b0001, 4'b0000, 4'b0000}, // R6
        {4'b0010, 1'b0, 3'd0, 8'd0,   2'd1, 4'b0010, 4'b0010, 4'b0000}, // R7 error set vs clear
        {4'b0000, 1'b1, 3'd1, 8'd32,  2'd0, 4'b0000, 4'b0110, 4'b0000}, // R8 at level 32
        {4'b0000, 1'b1, 3'd1, 8'd33,  2'd1, 4'b0110, 4'b0000, 4'b0000}, // R8 above level
        {4'b0000, 1'b1, 3'd0, 8'd0,   2'd0, 4'b0000, 4'b0100, 4'b0000}, // R8 code 0 empty
        {4'b0000, 1'b1, 3'd7, 8'd224, 2'd2, 4'b0100, 4'b0100, 4'b0000}, // R7 rearm vs clear
        {4'b0000, 1'b0, 3'd0, 8'd0,   2'd2, 4'b0100, 4'b0000, 4'b0000}, // R6
        {4'b0000, 1'b0, 3'd7, 8'd0,   2'd0, 4'b0000, 4'b0000, 4'b0000}, // R9 disabled
        {4'b0000, 1'b1, 3'd7, 8'd225, 2'd0, 4'b0000, 4'b0000, 4'b0000}, // R8 one above 224
        {4'b1111, 1'b0, 3'd0, 8'd0,   2'd3, 4'b0101, 4'b1111, 4'b0101}  // R1 all, R2 masked
    };

    task automatic chk4(input string req, input string what,
                        input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] s, input logic fe, input logic [2:0] c,
                         input logic [7:0] n, input logic [1:0] op, input logic [3:0] d);
        src_set = s; fifo_en = fe; tx_code = c; tx_count = n;
        pend_wr = (op == 2'd1); src_wr = (op == 2'd2); mask_wr = (op == 2'd3);
        wr_data = d;
    endtask

    // Watchdog: a hung run is a failure and still reports
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk4("R10", "src after reset", src_q, 4'b0);
        chk4("R10", "mask after reset", mask_q, 4'b0);
        chk4("R10", "irq after reset", {3'b0, irq}, 4'b0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            logic [3:0] es, em, ep;
            drive(VEC[i][29:26], VEC[i][25], VEC[i][24:22], VEC[i][21:14],
                  VEC[i][13:12], VEC[i][11:8]);
            @(negedge clk);
            es = VEC[i][7:4]; em = VEC[i][3:0]; ep = es & ~em;
            chk4("R1/R5/R6/R7/R8/R9", $sformatf("row %0d src", i), src_q, es);
            chk4("R4", $sformatf("row %0d mask", i), mask_q, em);
            chk4("R2", $sformatf("row %0d pend", i), pend_q, ep);
            chk4("R3", $sformatf("row %0d irq", i), {3'b0, irq}, {3'b0, |prev_pend});
            prev_pend = ep;
        end
        // R10: reset mid-run, set pulses during reset are ignored
        drive(4'b1111, 1'b1, 3'd0, 8'd0, 2'd0, 4'b0);
        rst_n = 1'b0;
        @(negedge clk);
        chk4("R10", "src in reset", src_q, 4'b0);
        chk4("R10", "mask in reset", mask_q, 4'b0);
        chk4("R10", "irq in reset", {3'b0, irq}, 4'b0);
        drive(4'b0000, 1'b0, 3'd0, 8'd0, 2'd0, 4'b0);
        rst_n = 1'b1;
        // R8: count 7 with code 3 is under 96 (ch0) but over 6 (ch2)
        drive(4'b0000, 1'b1, 3'd3, 8'd7, 2'd0, 4'b0);
        @(negedge clk);
        chk4("R8", "ch0 count 7 code 3", src_q, 4'b0100);
        chk4("R8", "ch2 count 7 code 3", src_q2, 4'b0000);
        drive(4'b0000, 1'b0, 3'd0, 8'd0, 2'd2, 4'b0100);
        @(negedge clk);
        chk4("R6", "ch2 clear", src_q2, 4'b0000);
        drive(4'b0000, 1'b1, 3'd3, 8'd6, 2'd0, 4'b0);
        @(negedge clk);
        chk4("R8", "ch2 count 6 code 3", src_q2, 4'b0100);
        // R3: irq lags pending by one edge on the second instance
        chk4("R3", "ch2 irq lag", {3'b0, irq2}, 4'b0);
        drive(4'b0000, 1'b0, 3'd0, 8'd0, 2'd0, 4'b0);
        @(negedge clk);
        chk4("R3", "ch2 irq follows", {3'b0, irq2}, 4'b0001);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule